// File: doc/BRIEF.md
# Command Ring Processor

This block works through a ring of fixed 128-bit commands that software places in system memory. Software sets the ring's base address and its length in bytes, and it moves the tail offset forward after it writes new entries. Whenever the hardware head offset differs from the tail offset and processing is enabled, the block reads the entry at the head and decodes it. It then acts on the entry through one of these outputs:

- one of four invalidation request ports,
- a memory write port,
- an event output.

Invalidations use a two-phase protocol. A request/acknowledge handshake hands the command to the target cache. That cache later sends a separate done pulse when the work is finished. Several invalidations may therefore be in flight on each port at once. A synchronisation command acts as a barrier: it waits until every invalidation issued before it has reported done. It can then store a 64-bit value to memory and raise a notification pulse.

If a fetch returns a bus error, or an entry carries an opcode that is not defined, the block reports an event and halts. While halted it fetches nothing. Software clears the halt by dropping the enable bit. When enable returns, the block fetches again at the head entry that was not retired.

Top module: `cmdring_proc`

## Requirements
- R1: After reset, `head_ptr` equals `ring_base`, `halted` is low, and none of `rd_req`, `inv_req` or `wr_req` is asserted.
- R2: While `cmd_en` is high and not halted, the block fetches when the head offset differs from `tail_off`. The fetch address `ring_base` + head offset is 16-byte aligned and lies inside the ring. When head equals tail, no fetch is made.
- R3: Each retired command advances the head by 16 bytes. When the new offset would reach `ring_len`, the head returns to offset 0.
- R4: The opcode sits in command bits [63:60]. Opcode 1 selects port 0 (device context), 2 selects port 1 (domain translations), 3 selects port 2 (remote device cache), and 4 selects port 3 (interrupt table). On the selected port `inv_cmd` carries the full command. Only one `inv_req` bit is high at a time, and it stays high until acknowledged.
- R5: Opcode 5 (barrier) does not store or notify until every earlier accepted invalidation has signalled `inv_done`.
- R6: A barrier with bit 57 set writes command bits [127:64] to the address formed from command bits [ADDR_W-1:3] with three zero low bits. The write request is held until `wr_ack`.
- R7: A barrier with bit 56 set gives a one-cycle `comp_irq` pulse once its drain and any store have finished.
- R8: Any opcode other than 1 to 5 produces an event with code 2 and `evt_addr` equal to that entry's address. The block halts and the head does not move.
- R9: A fetch that returns `rd_err` produces an event with code 1 and that entry's address, and the block halts.
- R10: Dropping `cmd_en` lets the command in progress retire. No further fetch happens until `cmd_en` returns.
- R11: While halted no request is made on any port. Dropping `cmd_en` clears the halt, and re-enabling re-fetches the entry at the head.
- R12: No port has more than MAX_OUT invalidations accepted and not yet done. Issue on a full port waits for a done pulse. A done pulse and a new acceptance in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en | input | 1 | Processing enable |
| ring_base | input | ADDR_W | Ring base address, 16-byte aligned |
| ring_len | input | OFF_W | Ring length in bytes, a nonzero multiple of 16 |
| tail_off | input | OFF_W | Software tail offset |
| head_ptr | output | ADDR_W | Current head address |
| rd_req | output | 1 | Command fetch request |
| rd_addr | output | ADDR_W | Fetch address |
| rd_valid | input | 1 | Fetch data returned |
| rd_err | input | 1 | Fetch bus error, qualified by rd_valid |
| rd_data | input | 128 | Fetched command |
| inv_req | output | 4 | Invalidation request, one bit per port |
| inv_ack | input | 4 | Invalidation accepted |
| inv_done | input | 4 | Invalidation finished, one pulse each |
| inv_cmd | output | 128 | Command forwarded to the invalidation ports |
| wr_req | output | 1 | Barrier store request |
| wr_addr | output | ADDR_W | Store address |
| wr_data | output | 64 | Store value |
| wr_ack | input | 1 | Store accepted |
| comp_irq | output | 1 | Barrier notification pulse |
| evt_valid | output | 1 | Error event pulse |
| evt_code | output | 2 | 1 fetch error, 2 illegal opcode |
| evt_addr | output | ADDR_W | Address of the failing entry |
| halted | output | 1 | Processing stopped by an error |

## Verification
Two things can land in the same cycle. One is a done pulse that frees a tracker slot. The other is either a new acceptance on the same port or the barrier's check of the outstanding count. The bench provokes this by sweeping the done latency across bursts of three invalidations to one port, each burst followed by a barrier, so that done pulses line up with later acknowledges in many phases. The result is judged in two ways. Each store or notification must appear only after the bench's own count of unfinished invalidations has reached zero. No port's count may ever exceed MAX_OUT.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

   localparam int CMD_W       = 128;
   localparam int N_INV       = 4;
   localparam int ENTRY_BYTES = 16;

   localparam logic [3:0] OP_INV_DEVCTX = 4'd1;
   localparam logic [3:0] OP_INV_DOMAIN = 4'd2;
   localparam logic [3:0] OP_INV_REMOTE = 4'd3;
   localparam logic [3:0] OP_INV_INTTAB = 4'd4;
   localparam logic [3:0] OP_BARRIER    = 4'd5;

   localparam logic [1:0] EVT_FETCH_ERR = 2'd1;
   localparam logic [1:0] EVT_BAD_OP    = 2'd2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_EXEC,
      ST_ISSUE,
      ST_DRAIN,
      ST_STORE,
      ST_HALT
   } ring_st_e;

   typedef struct packed {
      logic       illegal;
      logic       is_inv;
      logic [1:0] port;
      logic       store;
      logic       notify;
   } cmd_dec_t;

endpackage

// File: rtl/cmdring_decode.sv
module cmdring_decode
   import cmdring_pkg::*;
(
   input  logic [3:0] opcode,
   input  logic [1:0] flags,
   output cmd_dec_t   dec
);

   always_comb begin
      dec         = '0;
      dec.store   = flags[1];
      dec.notify  = flags[0];
      unique case (opcode)
         OP_INV_DEVCTX: begin dec.is_inv = 1'b1; dec.port = 2'd0; end
         OP_INV_DOMAIN: begin dec.is_inv = 1'b1; dec.port = 2'd1; end
         OP_INV_REMOTE: begin dec.is_inv = 1'b1; dec.port = 2'd2; end
         OP_INV_INTTAB: begin dec.is_inv = 1'b1; dec.port = 2'd3; end
         OP_BARRIER:    dec.is_inv = 1'b0;
         default:       dec.illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/cmdring_ptr.sv
module cmdring_ptr
   import cmdring_pkg::*;
#(
   parameter int OFF_W = 16
)
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [OFF_W-1:0] ring_len,
   input  logic [OFF_W-1:0] tail_off,
   output logic [OFF_W-1:0] head_off,
   output logic             empty
);

   localparam logic [OFF_W:0] STEP = (OFF_W+1)'(ENTRY_BYTES);

   logic [OFF_W-1:0] head_q;
   logic [OFF_W:0]   sum_w;
   logic             wrap;

   assign sum_w = {1'b0, head_q} + STEP;
   assign wrap  = sum_w >= {1'b0, ring_len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
      end else if (adv) begin
         head_q <= wrap ? '0 : sum_w[OFF_W-1:0];
      end
   end

   assign head_off = head_q;
   assign empty    = head_q == tail_off;

endmodule

// File: rtl/cmdring_track.sv
module cmdring_track #(
   parameter int N       = 4,
   parameter int MAX_OUT = 2
)
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] issue,
   input  logic [N-1:0] done,
   output logic [N-1:0] full,
   output logic         busy_any
);

   localparam int CNT_W = $clog2(MAX_OUT + 1);

   logic [N-1:0] busy;

   for (genvar i = 0; i < N; i++) begin : g_port
      if (MAX_OUT == 1) begin : g_flag
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
            end else if (issue[i]) begin
               pend_q <= 1'b1;
            end else if (done[i]) begin
               pend_q <= 1'b0;
            end
         end
         assign full[i] = pend_q;
         assign busy[i] = pend_q;
      end else begin : g_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else begin
               unique case ({issue[i], done[i]})
                  2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                  2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                  default: cnt_q <= cnt_q;
               endcase
            end
         end
         assign full[i] = cnt_q == CNT_W'(MAX_OUT);
         assign busy[i] = cnt_q != '0;
      end
   end

   assign busy_any = |busy;

endmodule

// File: rtl/cmdring_proc.sv
module cmdring_proc
   import cmdring_pkg::*;
#(
   parameter int ADDR_W  = 48,
   parameter int OFF_W   = 16,
   parameter int MAX_OUT = 2
)
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_en,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic [OFF_W-1:0]  ring_len,
   input  logic [OFF_W-1:0]  tail_off,
   output logic [ADDR_W-1:0] head_ptr,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_valid,
   input  logic              rd_err,
   input  logic [127:0]      rd_data,
   output logic [3:0]        inv_req,
   input  logic [3:0]        inv_ack,
   input  logic [3:0]        inv_done,
   output logic [127:0]      inv_cmd,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [63:0]       wr_data,
   input  logic              wr_ack,
   output logic              comp_irq,
   output logic              evt_valid,
   output logic [1:0]        evt_code,
   output logic [ADDR_W-1:0] evt_addr,
   output logic              halted
);

   if (ADDR_W < 16 || ADDR_W > 56) begin : g_bad_addr_w
      $error("cmdring_proc: ADDR_W must lie in 16..56");
   end
   if (OFF_W < 5 || OFF_W > ADDR_W) begin : g_bad_off_w
      $error("cmdring_proc: OFF_W must lie in 5..ADDR_W");
   end
   if (MAX_OUT < 1) begin : g_bad_max_out
      $error("cmdring_proc: MAX_OUT must be at least 1");
   end

   ring_st_e          st_q, st_d;
   logic [CMD_W-1:0]  cmd_q;
   cmd_dec_t          dec;
   logic [OFF_W-1:0]  head_off;
   logic              ring_empty;
   logic              adv;
   logic [N_INV-1:0]  port_full;
   logic [N_INV-1:0]  port_sel;
   logic [N_INV-1:0]  issue;
   logic              busy_any;
   logic [ADDR_W-1:0] head_addr;
   logic              evt_set;
   logic [1:0]        evt_code_d;
   logic              irq_set;
   logic              evt_valid_q;
   logic [1:0]        evt_code_q;
   logic [ADDR_W-1:0] evt_addr_q;
   logic              irq_q;

   cmdring_decode u_dec (
      .opcode (cmd_q[63:60]),
      .flags  (cmd_q[57:56]),
      .dec    (dec)
   );

   cmdring_ptr #(.OFF_W(OFF_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .ring_len (ring_len),
      .tail_off (tail_off),
      .head_off (head_off),
      .empty    (ring_empty)
   );

   cmdring_track #(.N(N_INV), .MAX_OUT(MAX_OUT)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (issue),
      .done     (inv_done),
      .full     (port_full),
      .busy_any (busy_any)
   );

   assign head_addr = ring_base + ADDR_W'(head_off);
   assign port_sel  = N_INV'(1) << dec.port;
   assign issue     = inv_req & inv_ack;

   always_comb begin
      st_d       = st_q;
      adv        = 1'b0;
      evt_set    = 1'b0;
      evt_code_d = EVT_FETCH_ERR;
      irq_set    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (cmd_en && !ring_empty) st_d = ST_FETCH;
         end
         ST_FETCH: begin
            if (rd_valid) begin
               if (rd_err) begin
                  evt_set    = 1'b1;
                  evt_code_d = EVT_FETCH_ERR;
                  st_d       = ST_HALT;
               end else begin
                  st_d = ST_EXEC;
               end
            end
         end
         ST_EXEC: begin
            if (dec.illegal) begin
               evt_set    = 1'b1;
               evt_code_d = EVT_BAD_OP;
               st_d       = ST_HALT;
            end else if (dec.is_inv) begin
               st_d = ST_ISSUE;
            end else begin
               st_d = ST_DRAIN;
            end
         end
         ST_ISSUE: begin
            if (|issue) begin
               adv  = 1'b1;
               st_d = ST_IDLE;
            end
         end
         ST_DRAIN: begin
            if (!busy_any) begin
               if (dec.store) begin
                  st_d = ST_STORE;
               end else begin
                  irq_set = dec.notify;
                  adv     = 1'b1;
                  st_d    = ST_IDLE;
               end
            end
         end
         ST_STORE: begin
            if (wr_ack) begin
               irq_set = dec.notify;
               adv     = 1'b1;
               st_d    = ST_IDLE;
            end
         end
         ST_HALT: begin
            if (!cmd_en) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         cmd_q       <= '0;
         evt_valid_q <= 1'b0;
         evt_code_q  <= '0;
         evt_addr_q  <= '0;
         irq_q       <= 1'b0;
      end else begin
         st_q        <= st_d;
         evt_valid_q <= evt_set;
         irq_q       <= irq_set;
         if (evt_set) begin
            evt_code_q <= evt_code_d;
            evt_addr_q <= head_addr;
         end
         if (st_q == ST_FETCH && rd_valid) begin
            cmd_q <= rd_data;
         end
      end
   end

   assign head_ptr  = head_addr;
   assign rd_req    = st_q == ST_FETCH;
   assign rd_addr   = head_addr;
   assign inv_req   = (st_q == ST_ISSUE) ? (port_sel & ~port_full) : '0;
   assign inv_cmd   = cmd_q;
   assign wr_req    = st_q == ST_STORE;
   assign wr_addr   = {cmd_q[ADDR_W-1:3], 3'b000};
   assign wr_data   = cmd_q[127:64];
   assign comp_irq  = irq_q;
   assign evt_valid = evt_valid_q;
   assign evt_code  = evt_code_q;
   assign evt_addr  = evt_addr_q;
   assign halted    = st_q == ST_HALT;

endmodule

// File: rtl/cmdring_chk.sv
module cmdring_chk #(
   parameter int ADDR_W = 48,
   parameter int OFF_W  = 16
)
(
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [3:0]        inv_req,
   input logic [3:0]        inv_ack,
   input logic              wr_req,
   input logic              wr_ack,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              busy_any,
   input logic              evt_valid,
   input logic              halted,
   input logic [ADDR_W-1:0] head_ptr,
   input logic [ADDR_W-1:0] ring_base,
   input logic [OFF_W-1:0]  ring_len
);

   a_r2_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

   a_r3_head_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_len != '0) |-> ((head_ptr - ring_base) < ADDR_W'(ring_len)));

   a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(inv_req));

   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (|(inv_req & ~inv_ack)) |=> (inv_req == $past(inv_req)));

   a_r5_store_drained: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> !busy_any);

   a_r6_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && !wr_ack |=> wr_req && $stable(wr_addr));

   a_r8_event_halts: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> halted);

   a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!rd_req && inv_req == 4'b0000 && !wr_req));

endmodule

bind cmdring_proc cmdring_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_req    (rd_req),
   .rd_valid  (rd_valid),
   .rd_addr   (rd_addr),
   .inv_req   (inv_req),
   .inv_ack   (inv_ack),
   .wr_req    (wr_req),
   .wr_ack    (wr_ack),
   .wr_addr   (wr_addr),
   .busy_any  (busy_any),
   .evt_valid (evt_valid),
   .halted    (halted),
   .head_ptr  (head_ptr),
   .ring_base (ring_base),
   .ring_len  (ring_len)
);

// File: tb/cmdring_proc_tb_top.sv
`timescale 1ns/1ps
module cmdring_proc_tb_top;

   localparam int ADDR_W  = 48;
   localparam int OFF_W   = 16;
   localparam int MAX_OUT = 2;
   localparam int LEN     = 128;
   localparam int SLOTS   = LEN / 16;
   localparam int RD_LAT  = 2;
   localparam logic [ADDR_W-1:0] BASE = 48'h0000_1234_5000;

   typedef struct {
      int           kind;
      logic [127:0] data;
      string        req;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_en = 1'b0;
   logic [ADDR_W-1:0] ring_base = BASE;
   logic [OFF_W-1:0]  ring_len = OFF_W'(LEN);
   logic [OFF_W-1:0]  tail_off = '0;
   logic [ADDR_W-1:0] head_ptr;
   logic              rd_req;
   logic [ADDR_W-1:0] rd_addr;
   logic              rd_valid = 1'b0;
   logic              rd_err = 1'b0;
   logic [127:0]      rd_data = '0;
   logic [3:0]        inv_req;
   logic [3:0]        inv_ack = '0;
   logic [3:0]        inv_done = '0;
   logic [127:0]      inv_cmd;
   logic              wr_req;
   logic [ADDR_W-1:0] wr_addr;
   logic [63:0]       wr_data;
   logic              wr_ack = 1'b0;
   logic              comp_irq;
   logic              evt_valid;
   logic [1:0]        evt_code;
   logic [ADDR_W-1:0] evt_addr;
   logic              halted;

   always #4 clk = ~clk;

   cmdring_proc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .MAX_OUT(MAX_OUT)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .ring_base(ring_base),
      .ring_len(ring_len), .tail_off(tail_off), .head_ptr(head_ptr),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_err(rd_err),
      .rd_data(rd_data), .inv_req(inv_req), .inv_ack(inv_ack),
      .inv_done(inv_done), .inv_cmd(inv_cmd), .wr_req(wr_req),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
      .comp_irq(comp_irq), .evt_valid(evt_valid), .evt_code(evt_code),
      .evt_addr(evt_addr), .halted(halted)
   );

   int n_chk = 0;
   int n_bad = 0;
   item_t exp_q[$];
   logic [127:0] mem [SLOTS];
   logic [ADDR_W-1:0] err_addr = '1;
   int ack_dly = 0;
   int done_dly = 1;
   int rd_cnt = 0;
   int rd_seen = 0;
   int wr_cnt = 0;
   logic [127:0] wr_cap = '0;
   logic [127:0] cap [4];
   logic [63:0] sched [4];
   int tb_out [4];
   int max_seen [4];
   int ack_cnt [4];

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp, input string what);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic record(input int kind, input logic [127:0] data);
      item_t it;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R4", data, '0, $sformatf("unexpected item kind %0d", kind));
      end else begin
         it = exp_q.pop_front();
         chk(it.kind == kind && it.data == data, it.req, data, it.data,
             $sformatf("item kind %0d vs %0d", kind, it.kind));
      end
   endtask

   task automatic barrier_chk(input string req);
      bit clear = 1'b1;
      for (int p = 0; p < 4; p++) begin
         if (tb_out[p] != 0 || sched[p] != '0) clear = 1'b0;
      end
      chk(clear, req, 128'(tb_out[0] + tb_out[1] + tb_out[2] + tb_out[3]), '0,
          "barrier output before all done");
   endtask

   // responders and monitor: everything is sampled and driven at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_valid) begin
            rd_valid = 1'b0;
            rd_err   = 1'b0;
         end else if (rd_req) begin
            rd_seen++;
            if (rd_cnt == 0) begin
               rd_cnt = RD_LAT;
               chk(((rd_addr - BASE) < ADDR_W'(LEN)) && rd_addr[3:0] == 4'h0, "R2",
                   128'(rd_addr), 128'(BASE), "fetch address outside ring");
            end
            rd_cnt--;
            if (rd_cnt == 0) begin
               rd_data  = mem[(rd_addr - BASE) >> 4];
               rd_err   = rd_addr == err_addr;
               rd_valid = 1'b1;
            end
         end
         for (int p = 0; p < 4; p++) begin
            inv_done[p] = 1'b0;
            if (sched[p][0]) begin
               inv_done[p] = 1'b1;
               tb_out[p]--;
            end
            sched[p] = sched[p] >> 1;
            if (inv_ack[p]) begin
               inv_ack[p] = 1'b0;
               record(p, cap[p]);
               tb_out[p]++;
               if (tb_out[p] > max_seen[p]) max_seen[p] = tb_out[p];
               sched[p][done_dly-1] = 1'b1;
            end else if (inv_req[p]) begin
               if (ack_cnt[p] >= ack_dly) begin
                  inv_ack[p] = 1'b1;
                  cap[p]     = inv_cmd;
                  ack_cnt[p] = 0;
               end else begin
                  ack_cnt[p]++;
               end
            end
         end
         if (wr_ack) begin
            wr_ack = 1'b0;
            record(4, wr_cap);
         end else if (wr_req) begin
            if (wr_cnt == 0) barrier_chk("R5");
            wr_cnt++;
            if (wr_cnt >= 2) begin
               wr_ack = 1'b1;
               wr_cap = {16'h0, wr_addr, wr_data};
               wr_cnt = 0;
            end
         end
         if (comp_irq) begin
            barrier_chk("R5");
            record(5, '0);
         end
         if (evt_valid) record(6, {62'd0, evt_code, 16'd0, evt_addr});
      end
   end

   function automatic logic [127:0] mk_inv(input logic [3:0] op, input logic [63:0] arg);
      return {arg, op, arg[59:0]};
   endfunction

   function automatic logic [127:0] mk_sync(input bit st, input bit irq,
                                            input logic [55:0] addr, input logic [63:0] data);
      return {data, 4'h5, 2'b00, st, irq, addr[55:3], 3'b000};
   endfunction

   task automatic expect_item(input int kind, input logic [127:0] data, input string req);
      item_t it;
      it.kind = kind;
      it.data = data;
      it.req  = req;
      exp_q.push_back(it);
   endtask

   task automatic put_cmd(input logic [127:0] c);
      mem[tail_off >> 4] = c;
      @(negedge clk);
      tail_off = OFF_W'((int'(tail_off) + 16) % LEN);
   endtask

   task automatic send_inv(input int port, input logic [63:0] arg, input string req);
      logic [127:0] c;
      c = mk_inv(4'(port + 1), arg);
      expect_item(port, c, req);
      put_cmd(c);
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while ((exp_q.size() != 0 || head_ptr != BASE + ADDR_W'(tail_off)) && n < 3000) begin
         @(negedge clk);
         n++;
      end
      repeat (6) @(negedge clk);
      chk(exp_q.size() == 0 && head_ptr == BASE + ADDR_W'(tail_off), req,
          128'(head_ptr), 128'(BASE + ADDR_W'(tail_off)), "ring did not drain");
   endtask

   task automatic wait_queue();
      int n = 0;
      while (exp_q.size() != 0 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [ADDR_W-1:0] h;
      logic [127:0] c;
      int snap;
      for (int p = 0; p < 4; p++) begin
         sched[p] = '0; tb_out[p] = 0; max_seen[p] = 0; ack_cnt[p] = 0; cap[p] = '0;
      end
      for (int i = 0; i < SLOTS; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(head_ptr == BASE, "R1", 128'(head_ptr), 128'(BASE), "head after reset");
      chk(!rd_req && inv_req == 4'b0 && !wr_req, "R1",
          {inv_req, rd_req, wr_req}, '0, "requests after reset");
      chk(!halted, "R1", 128'(halted), '0, "halted after reset");
      cmd_en = 1'b1;

      // R4 with R2: one command per port type
      for (int p = 0; p < 4; p++) send_inv(p, 64'hA000_0000_0000_0000 | 64'(p * 77 + 5), "R4");
      wait_idle("R2");
      chk(head_ptr == BASE + 48'd64, "R3", 128'(head_ptr), 128'(BASE + 48'd64), "head after four");

      // R3: wrap past the end of the ring
      for (int i = 0; i < 6; i++) send_inv(i % 4, 64'h0B00 + 64'(i), "R3");
      wait_idle("R3");
      chk(head_ptr == BASE + 48'd32, "R3", 128'(head_ptr), 128'(BASE + 48'd32), "head after wrap");

      // R5 R6 R7: barrier behind slow invalidations, with store and notify
      done_dly = 20;
      send_inv(0, 64'h1111, "R5");
      send_inv(1, 64'h2222, "R5");
      c = mk_sync(1'b1, 1'b1, 56'h00_0000_BEEF_1238, 64'hDEAD_0001_CAFE_0002);
      expect_item(4, {16'h0, 48'h0000_BEEF_1238, 64'hDEAD_0001_CAFE_0002}, "R6");
      expect_item(5, '0, "R7");
      put_cmd(c);
      wait_idle("R6");

      // R7: notify only, no store
      send_inv(3, 64'h3333, "R5");
      expect_item(5, '0, "R7");
      put_cmd(mk_sync(1'b0, 1'b1, 56'h0, 64'h0));
      wait_idle("R7");

      // R12: full port stalls, then a sweep of done latencies
      done_dly = 40;
      for (int i = 0; i < 3; i++) send_inv(2, 64'h4400 + 64'(i), "R12");
      expect_item(5, '0, "R12");
      put_cmd(mk_sync(1'b0, 1'b1, 56'h0, 64'h0));
      wait_idle("R12");
      chk(max_seen[2] == MAX_OUT, "R12", 128'(max_seen[2]), 128'(MAX_OUT), "port 2 peak");
      for (int d = 1; d <= 9; d++) begin
         done_dly = d;
         ack_dly  = d % 3;
         for (int i = 0; i < 3; i++) send_inv(d % 4, 64'h5500 + 64'(d * 8 + i), "R12");
         expect_item(5, '0, "R5");
         put_cmd(mk_sync(1'b0, 1'b1, 56'h0, 64'h0));
         wait_idle("R12");
      end
      for (int p = 0; p < 4; p++)
         chk(max_seen[p] <= MAX_OUT, "R12", 128'(max_seen[p]), 128'(MAX_OUT), "outstanding limit");
      done_dly = 1;

      // R10: drop enable while a command is in flight
      ack_dly = 12;
      for (int i = 0; i < 3; i++) send_inv(0, 64'h6600 + 64'(i), "R10");
      while (inv_req[0] !== 1'b1) @(negedge clk);
      h = head_ptr;
      cmd_en = 1'b0;
      snap = rd_seen;
      repeat (40) @(negedge clk);
      chk(head_ptr == BASE + ((h - BASE + 48'd16) % 48'(LEN)), "R10",
          128'(head_ptr), 128'(BASE + ((h - BASE + 48'd16) % 48'(LEN))), "head after disable");
      chk(rd_seen == snap, "R10", 128'(rd_seen), 128'(snap), "fetch while disabled");
      chk(exp_q.size() == 2, "R10", 128'(exp_q.size()), 128'd2, "pending commands");
      ack_dly = 0;
      cmd_en = 1'b1;
      wait_idle("R10");

      // R8 and R11: illegal opcode halts, enable toggle restarts
      h = head_ptr;
      expect_item(6, {62'd0, 2'd2, 16'd0, h}, "R8");
      put_cmd({64'h0, 4'hF, 60'h0});
      wait_queue();
      chk(halted, "R8", 128'(halted), 128'd1, "halted after bad opcode");
      chk(head_ptr == h, "R8", 128'(head_ptr), 128'(h), "head held on bad opcode");
      chk(!rd_req, "R11", 128'(rd_req), '0, "fetch while halted");
      c = mk_inv(4'd4, 64'h7777);
      mem[(h - BASE) >> 4] = c;
      expect_item(3, c, "R11");
      cmd_en = 1'b0;
      repeat (2) @(negedge clk);
      chk(!halted, "R11", 128'(halted), '0, "halt cleared by disable");
      cmd_en = 1'b1;
      wait_idle("R11");

      // R9: fetch bus error
      h = head_ptr;
      err_addr = h;
      c = mk_inv(4'd2, 64'h8888);
      expect_item(6, {62'd0, 2'd1, 16'd0, h}, "R9");
      put_cmd(c);
      wait_queue();
      chk(halted, "R9", 128'(halted), 128'd1, "halted after fetch error");
      chk(head_ptr == h, "R9", 128'(head_ptr), 128'(h), "head held on fetch error");
      err_addr = '1;
      expect_item(1, c, "R11");
      cmd_en = 1'b0;
      repeat (2) @(negedge clk);
      cmd_en = 1'b1;
      wait_idle("R9");

      // R2: empty ring makes no fetch
      snap = rd_seen;
      repeat (20) @(negedge clk);
      chk(rd_seen == snap, "R2", 128'(rd_seen), 128'(snap), "fetch on empty ring");

      finish_run();
   end

endmodule